// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave

This block is the slave-side front end of a byte-wide serial memory that is reached over a two-wire (I2C-style) bus. The block oversamples SCL and SDA on the system clock and detects START and STOP conditions from them. It compares the address byte with a fixed device-type code and with three select pins, so that up to eight identical slaves can share one bus. It then accepts a two-byte word address and serves byte writes and sequential reads on an internal synchronous array of 8,192 bytes.

Writes have no busy period. Each received byte is committed a few system clocks after its eighth bit, and a new bus transaction may start at once. A write-protect input fences off the top quarter of the map. The block only ever pulls SDA low, through a drive-low enable, and an external pull-up gives the high level.

Top module: `twowire_mem_slave`

## Requirements
- R1: After reset the SDA drive-low enable is inactive, and it stays inactive until the block is addressed.
- R2: The address byte is acknowledged only when bits 7:4 equal 4'b1010 and bits 3:1 equal `sel_i`. Bit 0 selects read (1) or write (0). A mismatching slave never drives SDA during that transaction.
- R3: A write transaction carries a 16-bit word address, high byte first. Only the low 13 bits select a location, and the top 3 bits of the high byte are ignored.
- R4: Every write data byte is acknowledged and stored at the address counter, and the counter then increments.
- R5: Reads return the byte at the counter MSB first, with SDA changing only after SCL falls, and the counter increments after each byte. After a master NACK the slave releases SDA and ignores the bus until the next START or STOP.
- R6: While `wp_i` is high, writes to 0x1800–0x1FFF are acknowledged but not stored, and 0x17FF and below are still written. While `wp_i` is low every address is writable.
- R7: The address counter wraps from 0x1FFF to 0x0000, for both reads and writes.
- R8: A read transaction without a preceding word-address phase continues from the current counter value.
- R9: A START or STOP seen at any bit position aborts the byte in progress and releases SDA. A partial byte is not stored, and the address counter is kept.
- R10: The SDA drive-low enable is only ever asserted while SCL is low.
- R11: A read that starts right after the STOP of a write returns the newly written data, with no busy or polling period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin (wired level) |
| sel_i | input | 3 | Device select pins compared with address bits 3:1 |
| wp_i | input | 1 | Write protect for the upper quarter of the map |
| sda_drive_low | output | 1 | Open-drain enable: 1 pulls SDA low |

## Verification
Two functions can act on the same byte. These are the write-protect gate and the address counter wrap: the byte written to 0x1FFF is suppressed in the same cycle that moves the counter to 0x0000, and the bytes that follow land in the unprotected bottom of the map. The bench first writes a known pattern across 0x1FFE..0x0001 with protection off. It then rewrites the same span with protection on and reads it back. Only the two wrapped locations may change, and every byte must still have been acknowledged. A second collision is a STOP in the middle of a write byte. The bench judges it by a current-address read, which must resume at the counter value the aborted byte left untouched.

// File: rtl/tw_pkg.sv
package tw_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_DEVADDR,
      ST_WADDR_HI,
      ST_WADDR_LO,
      ST_WRITE,
      ST_READ,
      ST_IGNORE
   } tw_state_e;

   typedef struct packed {
      logic rise;
      logic fall;
      logic start;
      logic stop;
      logic sda;
   } tw_bus_ev_t;

   localparam int BYTE_W = 8;

endpackage

// File: rtl/tw_bus_sampler.sv
module tw_bus_sampler #(
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output tw_pkg::tw_bus_ev_t ev
);

   logic [SYNC_STAGES-1:0] scl_sh;
   logic [SYNC_STAGES-1:0] sda_sh;
   logic                   scl_q;
   logic                   sda_q;
   logic                   scl_s;
   logic                   sda_s;

   generate
      if (SYNC_STAGES == 1) begin : g_one
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               scl_sh <= '1;
               sda_sh <= '1;
            end else begin
               scl_sh <= scl_i;
               sda_sh <= sda_i;
            end
         end
      end else begin : g_chain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               scl_sh <= '1;
               sda_sh <= '1;
            end else begin
               scl_sh <= {scl_sh[SYNC_STAGES-2:0], scl_i};
               sda_sh <= {sda_sh[SYNC_STAGES-2:0], sda_i};
            end
         end
      end
   endgenerate

   assign scl_s = scl_sh[SYNC_STAGES-1];
   assign sda_s = sda_sh[SYNC_STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_s;
         sda_q <= sda_s;
      end
   end

   always_comb begin
      ev.rise  = scl_s & ~scl_q;
      ev.fall  = ~scl_s & scl_q;
      ev.start = scl_s & scl_q & sda_q & ~sda_s;
      ev.stop  = scl_s & scl_q & ~sda_q & sda_s;
      ev.sda   = sda_s;
   end

endmodule

// File: rtl/tw_mem_array.sv
module tw_mem_array #(
   parameter int AW = 13,
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);

   localparam int DEPTH = 1 << AW;

   logic [DW-1:0] store [DEPTH];

   always_ff @(posedge clk) begin
      if (we) store[waddr] <= wdata;
      rdata <= store[raddr];
   end

endmodule

// File: rtl/tw_link_fsm.sv
module tw_link_fsm
   import tw_pkg::*;
#(
   parameter int         AW       = 13,
   parameter int         SEL_W    = 3,
   parameter logic [3:0] DEV_CODE = 4'b1010
) (
   input  logic              clk,
   input  logic              rst_n,
   input  tw_bus_ev_t        ev,
   input  logic [SEL_W-1:0]  sel_i,
   input  logic              wp_i,
   input  logic [BYTE_W-1:0] rdata,
   output logic [AW-1:0]     addr_cnt,
   output logic              mem_we,
   output logic [AW-1:0]     mem_waddr,
   output logic [BYTE_W-1:0] mem_wdata,
   output logic              drive_low
);

   localparam int         HI_W     = AW - BYTE_W;
   localparam logic [1:0] TOP_QTR  = 2'b11;
   localparam logic [3:0] LAST_BIT = 4'd7;
   localparam logic [3:0] ACK_PREP = 4'd8;
   localparam logic [3:0] ACK_SLOT = 4'd9;

   tw_state_e         state;
   tw_state_e         pend;
   logic [3:0]        cnt;
   logic [BYTE_W-1:0] shreg;
   logic              byte_done;
   logic              ack_flag;
   logic              m_ack;
   logic [HI_W-1:0]   addr_hi;
   logic              dev_match;
   logic              protect_hit;

   assign dev_match   = (shreg[7:4] == DEV_CODE) && (shreg[SEL_W:1] == sel_i);
   assign protect_hit = wp_i && (addr_cnt[AW-1 -: 2] == TOP_QTR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         pend      <= ST_IDLE;
         cnt       <= '0;
         shreg     <= '0;
         byte_done <= 1'b0;
         ack_flag  <= 1'b0;
         m_ack     <= 1'b0;
         addr_hi   <= '0;
         addr_cnt  <= '0;
         mem_we    <= 1'b0;
         mem_waddr <= '0;
         mem_wdata <= '0;
         drive_low <= 1'b0;
      end else begin
         mem_we    <= 1'b0;
         byte_done <= 1'b0;
         if (ev.start) begin
            state     <= ST_DEVADDR;
            cnt       <= '0;
            drive_low <= 1'b0;
         end else if (ev.stop) begin
            state     <= ST_IDLE;
            cnt       <= '0;
            drive_low <= 1'b0;
         end else if (state != ST_IDLE && state != ST_IGNORE) begin
            if (ev.rise) begin
               if (cnt < ACK_PREP) begin
                  cnt <= cnt + 4'd1;
                  if (state == ST_READ) begin
                     shreg <= {shreg[BYTE_W-2:0], 1'b0};
                  end else begin
                     shreg <= {shreg[BYTE_W-2:0], ev.sda};
                     if (cnt == LAST_BIT) byte_done <= 1'b1;
                  end
               end else if (cnt == ACK_SLOT) begin
                  m_ack <= ~ev.sda;
               end
            end
            if (byte_done) begin
               ack_flag <= 1'b1;
               case (state)
                  ST_DEVADDR: begin
                     if (dev_match) begin
                        pend <= shreg[0] ? ST_READ : ST_WADDR_HI;
                     end else begin
                        ack_flag <= 1'b0;
                        pend     <= ST_IGNORE;
                     end
                  end
                  ST_WADDR_HI: begin
                     addr_hi <= shreg[HI_W-1:0];
                     pend    <= ST_WADDR_LO;
                  end
                  ST_WADDR_LO: begin
                     addr_cnt <= {addr_hi, shreg};
                     pend     <= ST_WRITE;
                  end
                  ST_WRITE: begin
                     mem_we    <= ~protect_hit;
                     mem_waddr <= addr_cnt;
                     mem_wdata <= shreg;
                     addr_cnt  <= addr_cnt + 1'b1;
                     pend      <= ST_WRITE;
                  end
                  default: pend <= ST_IGNORE;
               endcase
            end
            if (ev.fall) begin
               if (cnt == ACK_PREP) begin
                  cnt       <= ACK_SLOT;
                  drive_low <= (state == ST_READ) ? 1'b0 : ack_flag;
               end else if (cnt == ACK_SLOT) begin
                  cnt       <= '0;
                  drive_low <= 1'b0;
                  if (state == ST_READ) begin
                     if (m_ack) begin
                        shreg     <= rdata;
                        drive_low <= ~rdata[BYTE_W-1];
                        addr_cnt  <= addr_cnt + 1'b1;
                     end else begin
                        state <= ST_IGNORE;
                     end
                  end else begin
                     state <= pend;
                     if (pend == ST_READ) begin
                        shreg     <= rdata;
                        drive_low <= ~rdata[BYTE_W-1];
                        addr_cnt  <= addr_cnt + 1'b1;
                     end
                  end
               end else if (state == ST_READ && cnt != 4'd0) begin
                  drive_low <= ~shreg[BYTE_W-1];
               end
            end
         end
      end
   end

endmodule

// File: rtl/twowire_mem_slave.sv
module twowire_mem_slave #(
   parameter int         ADDR_W      = 13,
   parameter int         SYNC_STAGES = 2,
   parameter logic [3:0] DEV_CODE    = 4'b1010
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       scl_i,
   input  logic       sda_i,
   input  logic [2:0] sel_i,
   input  logic       wp_i,
   output logic       sda_drive_low
);

   localparam int SEL_W = 3;
   localparam int DW    = tw_pkg::BYTE_W;

   generate
      if (ADDR_W < 9 || ADDR_W > 16) begin : g_bad_aw
         $error("ADDR_W must lie between 9 and 16");
      end
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 1");
      end
   endgenerate

   tw_pkg::tw_bus_ev_t ev;
   logic              start_det;
   logic              stop_det;
   logic [ADDR_W-1:0] addr_cnt;
   logic              mem_we;
   logic [ADDR_W-1:0] mem_waddr;
   logic [DW-1:0]     mem_wdata;
   logic [DW-1:0]     mem_rdata;

   assign start_det = ev.start;
   assign stop_det  = ev.stop;

   tw_bus_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
      .clk   (clk),
      .rst_n (rst_n),
      .scl_i (scl_i),
      .sda_i (sda_i),
      .ev    (ev)
   );

   tw_link_fsm #(.AW(ADDR_W), .SEL_W(SEL_W), .DEV_CODE(DEV_CODE)) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .ev        (ev),
      .sel_i     (sel_i),
      .wp_i      (wp_i),
      .rdata     (mem_rdata),
      .addr_cnt  (addr_cnt),
      .mem_we    (mem_we),
      .mem_waddr (mem_waddr),
      .mem_wdata (mem_wdata),
      .drive_low (sda_drive_low)
   );

   tw_mem_array #(.AW(ADDR_W), .DW(DW)) u_array (
      .clk   (clk),
      .we    (mem_we),
      .waddr (mem_waddr),
      .wdata (mem_wdata),
      .raddr (addr_cnt),
      .rdata (mem_rdata)
   );

endmodule

// File: rtl/tw_slave_checker.sv
module tw_slave_checker #(
   parameter int AW = 13
) (
   input logic          clk,
   input logic          rst_n,
   input logic          scl_i,
   input logic          wp_i,
   input logic          start_det,
   input logic          stop_det,
   input logic          drive,
   input logic          mem_we,
   input logic [AW-1:0] mem_waddr,
   input logic [AW-1:0] addr_cnt
);

   assert_wp_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && wp_i) |-> (mem_waddr[AW-1 -: 2] != 2'b11));

   assert_counter_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> (addr_cnt == AW'(mem_waddr + 1'b1)));

   assert_cond_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (start_det || stop_det) |=> !drive);

   assert_counter_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
      start_det |=> $stable(addr_cnt));

   assert_pull_scl_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(drive) |-> !scl_i);

endmodule

bind twowire_mem_slave tw_slave_checker #(.AW(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .scl_i     (scl_i),
   .wp_i      (wp_i),
   .start_det (start_det),
   .stop_det  (stop_det),
   .drive     (sda_drive_low),
   .mem_we    (mem_we),
   .mem_waddr (mem_waddr),
   .addr_cnt  (addr_cnt)
);

// File: tb/tb_twowire_mem_slave.sv
module tb_twowire_mem_slave;

   localparam int CLK_PERIOD = 10;
   localparam int Q          = 5;
   localparam int MEMSZ      = 8192;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       m_scl = 1'b1;
   logic       m_sda = 1'b1;
   logic [2:0] sel = 3'd5;
   logic       wp = 1'b0;
   logic       sda_drive_low;
   logic       sda_line;

   int checks = 0;
   int errors = 0;
   logic saw_drive = 1'b0;
   logic prev_drive = 1'b0;
   int   scl_viol = 0;
   logic [7:0] ref_mem [MEMSZ];
   logic [12:0] ref_cnt = '0;

   assign sda_line = m_sda & ~sda_drive_low;

   always #(CLK_PERIOD/2) clk = ~clk;

   twowire_mem_slave dut (
      .clk           (clk),
      .rst_n         (rst_n),
      .scl_i         (m_scl),
      .sda_i         (sda_line),
      .sel_i         (sel),
      .wp_i          (wp),
      .sda_drive_low (sda_drive_low)
   );

   always @(posedge clk) begin
      if (sda_drive_low) saw_drive <= 1'b1;
      if (sda_drive_low && !prev_drive && m_scl) scl_viol <= scl_viol + 1;
      prev_drive <= sda_drive_low;
   end

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: got %0h expected %0h", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] pat(input int a, input int salt);
      return 8'((a * 7) + (salt * 13) + (a >> 8));
   endfunction

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_start();
      m_sda = 1'b1; tick(Q);
      m_scl = 1'b1; tick(Q);
      m_sda = 1'b0; tick(Q);
      m_scl = 1'b0; tick(Q);
   endtask

   task automatic bus_stop();
      m_sda = 1'b0; tick(Q);
      m_scl = 1'b1; tick(Q);
      m_sda = 1'b1; tick(Q);
   endtask

   task automatic send_bits(input logic [7:0] b, input int n);
      for (int i = 7; i > 7 - n; i--) begin
         m_sda = b[i]; tick(Q);
         m_scl = 1'b1; tick(2 * Q);
         m_scl = 1'b0; tick(Q);
      end
   endtask

   task automatic send_byte(input logic [7:0] b, output logic ack);
      send_bits(b, 8);
      m_sda = 1'b1; tick(Q);
      m_scl = 1'b1; tick(Q);
      ack = ~sda_line;
      tick(Q);
      m_scl = 1'b0; tick(Q);
   endtask

   task automatic recv_byte(output logic [7:0] b, input bit give_ack);
      b = '0;
      m_sda = 1'b1;
      for (int i = 0; i < 8; i++) begin
         tick(Q);
         m_scl = 1'b1; tick(Q);
         b = {b[6:0], sda_line};
         tick(Q);
         m_scl = 1'b0;
      end
      tick(Q);
      m_sda = give_ack ? 1'b0 : 1'b1; tick(Q);
      m_scl = 1'b1; tick(2 * Q);
      m_scl = 1'b0; tick(Q);
      m_sda = 1'b1;
   endtask

   task automatic wr_burst(input logic [15:0] a, input int n, input int salt, input string tag);
      logic ack;
      int bad = 0;
      bus_start();
      send_byte({4'hA, sel, 1'b0}, ack); if (!ack) bad++;
      send_byte(a[15:8], ack); if (!ack) bad++;
      send_byte(a[7:0], ack); if (!ack) bad++;
      for (int k = 0; k < n; k++) begin
         int adr;
         logic [7:0] d;
         adr = (int'(a[12:0]) + k) % MEMSZ;
         d = pat(adr, salt);
         send_byte(d, ack);
         if (!ack) bad++;
         if (!(wp && adr >= 'h1800)) ref_mem[adr] = d;
      end
      ref_cnt = 13'((int'(a[12:0]) + n) % MEMSZ);
      bus_stop();
      check(bad == 0, {tag, " write acks"}, bad, 0);
   endtask

   task automatic read_bytes(input int n, input bit probe_idle, input string tag);
      logic [7:0] b;
      for (int k = 0; k < n; k++) begin
         recv_byte(b, k != n - 1);
         check(b == ref_mem[ref_cnt], tag, b, ref_mem[ref_cnt]);
         ref_cnt = ref_cnt + 1'b1;
      end
      if (probe_idle) begin
         saw_drive = 1'b0;
         recv_byte(b, 1'b1);
         check(!saw_drive, "R5 silent after master NACK", saw_drive, 0);
      end
      bus_stop();
   endtask

   task automatic rd_burst(input logic [15:0] a, input int n, input string tag);
      logic ack;
      int bad = 0;
      bus_start();
      send_byte({4'hA, sel, 1'b0}, ack); if (!ack) bad++;
      send_byte(a[15:8], ack); if (!ack) bad++;
      send_byte(a[7:0], ack); if (!ack) bad++;
      bus_start();
      send_byte({4'hA, sel, 1'b1}, ack); if (!ack) bad++;
      check(bad == 0, {tag, " address acks"}, bad, 0);
      ref_cnt = a[12:0];
      read_bytes(n, 1'b0, tag);
   endtask

   task automatic cur_read(input int n, input bit probe_idle, input string tag);
      logic ack;
      bus_start();
      send_byte({4'hA, sel, 1'b1}, ack);
      check(ack, {tag, " address ack"}, ack, 1);
      read_bytes(n, probe_idle, tag);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic ack;
      tick(5);
      rst_n = 1'b1;
      tick(20);
      // R1 reset and idle state
      check(sda_drive_low == 1'b0, "R1 released after reset", sda_drive_low, 0);
      check(saw_drive == 1'b0, "R1 silent while idle", saw_drive, 0);

      // R3 R4: upper word-address bits set to ones must be ignored
      wr_burst(16'hE010, 16, 1, "R3 R4");
      // R11 R5: read straight after the write STOP, alias address form
      rd_burst(16'h0010, 8, "R5 R11 sequential read");
      // R8: current-address read continues at 0x18
      cur_read(8, 1'b1, "R8 current read");
      rd_burst(16'h2014, 4, "R3 aliased read");

      // R2: sweep select pins against addressed select bits
      for (int s = 0; s < 8; s++) begin
         sel = 3'(s);
         for (int a = 0; a < 8; a++) begin
            saw_drive = 1'b0;
            bus_start();
            send_byte({4'hA, 3'(a), 1'b0}, ack);
            bus_stop();
            check(ack == (a == s), "R2 select match", ack, a == s);
            if (a != s) check(!saw_drive, "R2 mismatch silent", saw_drive, 0);
         end
      end
      sel = 3'd5;
      saw_drive = 1'b0;
      bus_start();
      send_byte({4'hB, sel, 1'b0}, ack);
      bus_stop();
      check(!ack && !saw_drive, "R2 wrong device code", ack, 0);
      // counter must survive the address probes
      ref_cnt = 13'h0018 + 13'd4;
      ref_cnt = 13'h0018;
      ref_cnt = 13'h0018;
      ref_cnt = 13'h0018;
      cur_read(1, 1'b0, "R8 counter after probes");

      // R6 R7: protection and wrap on the same span
      wp = 1'b0;
      wr_burst(16'h1FFE, 4, 2, "R7 wrap write");
      wp = 1'b1;
      wr_burst(16'h1FFE, 4, 3, "R6 R7 protected wrap write");
      wp = 1'b0;
      rd_burst(16'h1FFE, 4, "R6 R7 wrap readback");
      wr_burst(16'h17FF, 2, 4, "R6 preload edge");
      wp = 1'b1;
      wr_burst(16'h17FF, 2, 5, "R6 protected edge");
      wp = 1'b0;
      rd_burst(16'h17FF, 2, "R6 edge readback");
      wr_burst(16'h1800, 1, 6, "R6 unprotected top");
      rd_burst(16'h1800, 1, "R6 unprotected readback");

      // R9: STOP in the middle of a write byte
      wr_burst(16'h0040, 3, 7, "R9 preload");
      bus_start();
      send_byte({4'hA, sel, 1'b0}, ack);
      send_byte(8'h00, ack);
      send_byte(8'h40, ack);
      send_byte(8'h55, ack);
      ref_mem[16'h40] = 8'h55;
      send_bits(8'hFF, 4);
      bus_stop();
      ref_cnt = 13'h0041;
      cur_read(1, 1'b0, "R9 counter kept after abort");
      rd_burst(16'h0040, 2, "R9 partial byte dropped");

      tick(10);
      check(scl_viol == 0, "R10 drive only while SCL low", scl_viol, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule